// File: doc/BRIEF.md
# Configuration Revision Select Controller

This block sits beside a configuration memory that stores up to four design revisions, and it decides when a device restart takes place and which revision is read. A restart can come from three places: the power-on reset, an outside agent pulling the shared open-drain clear line low, or a single-cycle configuration command strobe from a test-access controller. On a command the block pulls the clear line low itself, once, for a fixed number of clock cycles that is sized to about 400 ns.

The block watches the clear line through a synchronizer. When the line goes from low to high, it latches the revision index and converts it into that revision's starting offset. The offset is counted in storage units, where one unit is 8 Mbit. The block then raises a one-cycle start strobe. The index comes from one of two sources, and a mode input chooses between them: external select pins or internally programmed select bits. Each revision's size comes from a small table that is loaded during reset. This lets the revisions have unequal sizes. An index that points past the end of the storage falls back to revision 0 and sets a sticky error flag.

Top module: `rev_sel_ctrl`

## Requirements
- R1: A command strobe seen while the clear drive is idle asserts `clr_drive_o` from the next cycle for exactly LOW_CYCLES consecutive cycles. LOW_CYCLES is ceil(400 ns / clock period), which is 40 at 10 ns, and elaboration rejects any value outside 300 to 500 ns.
- R2: A command strobe that arrives while `clr_drive_o` is already asserted, including on its last cycle, is ignored. The pulse is neither lengthened nor repeated, and only one start follows.
- R3: Every low-to-high transition of the clear line produces exactly one single-cycle `start_o`. This holds whether the block or an outside agent held the line low. `start_o` is high in the third cycle after the line rises.
- R4: When `use_int_i` is 1 the revision index is taken from `int_sel_i`; when it is 0, from `ext_sel_i`.
- R5: The size table is sampled while `rst_n` is low. Field n is bits [2n+1:2n], and code c means c+1 units. The base of revision n is the sum of the sizes of revisions 0 to n-1, and `base_o` shows the base of the latched revision.
- R6: If the latched revision's base plus size exceeds CAP_UNITS (4), `base_o` becomes 0 and `sel_err_o` is set. The flag stays set until the next reset.
- R7: With `rev_en_i` at 0, low levels on the clear line from outside are ignored and produce no start. A command still pulses the line and yields a start, and the latched index is forced to revision 0.
- R8: After reset is released, a single start strobe is issued in the first cycle, carrying the base of the selection present at that time.
- R9: While reset is active, `clr_drive_o`, `start_o` and `sel_err_o` are 0 and `base_o` is 0.
- R10: The selection inputs are sampled only at a latch event. Changing them afterwards leaves `base_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous for control state |
| cfg_cmd_i | input | 1 | Configuration command strobe |
| clr_line_i | input | 1 | Sensed level of the shared clear line |
| clr_drive_o | output | 1 | 1 pulls the open-drain clear line low |
| rev_en_i | input | 1 | Revisioning enable |
| use_int_i | input | 1 | 1 selects the internal select bits |
| ext_sel_i | input | 2 | External revision select pins |
| int_sel_i | input | 2 | Internal programmed revision select |
| size_tbl_i | input | 8 | Four 2-bit revision size codes |
| start_o | output | 1 | One-cycle configuration start strobe |
| base_o | output | 2 | Starting offset of the chosen revision in 8-Mbit units |
| sel_err_o | output | 1 | Sticky invalid-selection flag |

## Verification
After a command, the clear drive is due one cycle later and lasts LOW_CYCLES cycles. The bench samples at falling edges and counts those cycles directly, so any shortened or lengthened pulse is caught. The start strobe and the new base are due three rising edges after the line is released: two synchronizer stages, then the output register. Every trigger, whether from a command or from outside, is checked by counting falling edges from the release and requiring exactly one strobe at count 3. The power-on strobe is due at the first edge after reset is released and is sampled at the falling edge that follows.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction
endpackage

// File: rtl/rsc_pulse.sv
module rsc_pulse #(
   parameter int LOW_CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_i,
   output logic busy_o
);
   localparam int CNT_W = $clog2(LOW_CYCLES + 1);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         if (cmd_i) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(LOW_CYCLES - 1);
         end
      end else if (cnt_q == '0) begin
         busy_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = busy_q;

   logic [CNT_W:0] mon_len_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mon_len_q <= '0;
      else if (busy_q) mon_len_q <= mon_len_q + 1'b1;
      else             mon_len_q <= '0;
   end

   // R1
   pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> mon_len_q == (CNT_W+1)'(LOW_CYCLES));

   // R2
   late_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q == '0 && cmd_i) |=> !busy_q);
endmodule

// File: rtl/rsc_edge.sv
module rsc_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic rise_o
);
   logic [STAGES-1:0] sh_q;
   logic              prev_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= line_i;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= {sh_q[STAGES-2:0], line_i};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= sh_q[STAGES-1];
   end

   assign rise_o = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/rsc_table.sv
module rsc_table #(
   parameter int NREV      = 4,
   parameter int SZ_W      = 2,
   parameter int CAP_UNITS = 4,
   parameter int REV_W     = $clog2(NREV),
   parameter int SUM_W     = $clog2(NREV * (2 ** SZ_W) + 1)
) (
   input  logic [NREV*SZ_W-1:0] tbl_i,
   input  logic [REV_W-1:0]     sel_i,
   output logic [SUM_W-1:0]     base_o,
   output logic                 ok_o
);
   logic [SUM_W-1:0] size_a [NREV];
   logic [SUM_W-1:0] base_a [NREV];

   generate
      for (genvar g = 0; g < NREV; g++) begin : g_rev
         assign size_a[g] = SUM_W'(tbl_i[g*SZ_W +: SZ_W]) + SUM_W'(1);
         if (g == 0) begin : g_first
            assign base_a[g] = '0;
         end else begin : g_next
            assign base_a[g] = base_a[g-1] + size_a[g-1];
         end
      end
   endgenerate

   assign base_o = base_a[sel_i];
   assign ok_o   = (base_a[sel_i] + size_a[sel_i]) <= SUM_W'(CAP_UNITS);
endmodule

// File: rtl/rev_sel_ctrl.sv
module rev_sel_ctrl #(
   parameter int NREV        = 4,
   parameter int SZ_W        = 2,
   parameter int CAP_UNITS   = 4,
   parameter int CLK_NS      = 10,
   parameter int PULSE_NS    = 400,
   parameter int SYNC_STAGES = 2,
   localparam int REV_W      = $clog2(NREV),
   localparam int BASE_W     = $clog2(CAP_UNITS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_cmd_i,
   input  logic                 clr_line_i,
   output logic                 clr_drive_o,
   input  logic                 rev_en_i,
   input  logic                 use_int_i,
   input  logic [REV_W-1:0]     ext_sel_i,
   input  logic [REV_W-1:0]     int_sel_i,
   input  logic [NREV*SZ_W-1:0] size_tbl_i,
   output logic                 start_o,
   output logic [BASE_W-1:0]    base_o,
   output logic                 sel_err_o
);
   localparam int LOW_CYCLES = rsc_pkg::ceil_div(PULSE_NS, CLK_NS);
   localparam int SUM_W      = $clog2(NREV * (2 ** SZ_W) + 1);

   generate
      if (LOW_CYCLES * CLK_NS < 300 || LOW_CYCLES * CLK_NS > 500) begin : g_bad_pulse
         $error("clear pulse length outside 300..500 ns");
      end
      if (CAP_UNITS < 2 || SYNC_STAGES < 1 || NREV < 2) begin : g_bad_size
         $error("unsupported capacity, revision count or sync depth");
      end
   endgenerate

   logic                 busy;
   logic                 line_eff;
   logic                 rise;
   logic                 por_pend_q;
   logic [NREV*SZ_W-1:0] tbl_q;
   logic [REV_W-1:0]     sel_idx;
   logic [SUM_W-1:0]     base_sum;
   logic                 sel_ok;
   logic                 latch_ev;

   rsc_pulse #(.LOW_CYCLES(LOW_CYCLES)) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd_i  (cfg_cmd_i),
      .busy_o (busy)
   );

   assign clr_drive_o = busy;
   assign line_eff    = rev_en_i ? clr_line_i : ~busy;

   rsc_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (line_eff),
      .rise_o (rise)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) tbl_q <= size_tbl_i;
   end

   assign sel_idx = !rev_en_i ? '0 : (use_int_i ? int_sel_i : ext_sel_i);

   rsc_table #(.NREV(NREV), .SZ_W(SZ_W), .CAP_UNITS(CAP_UNITS)) u_table (
      .tbl_i  (tbl_q),
      .sel_i  (sel_idx),
      .base_o (base_sum),
      .ok_o   (sel_ok)
   );

   assign latch_ev = rise | por_pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         por_pend_q <= 1'b1;
         start_o    <= 1'b0;
         base_o     <= '0;
         sel_err_o  <= 1'b0;
      end else begin
         por_pend_q <= 1'b0;
         start_o    <= latch_ev;
         if (latch_ev) begin
            if (sel_ok) begin
               base_o <= base_sum[BASE_W-1:0];
            end else begin
               base_o    <= '0;
               sel_err_o <= 1'b1;
            end
         end
      end
   end

   // R3
   single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o);

   // R6
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_err_o |=> sel_err_o);

   // R6
   err_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_err_o) |-> (start_o && base_o == '0));

   // R10
   base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start_o |-> $stable(base_o));
endmodule

// File: tb/rev_sel_ctrl_tb.sv
module rev_sel_ctrl_tb;
   localparam int LC = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd = 1'b0;
   logic       ext_hold_n = 1'b1;
   logic       rev_en = 1'b1;
   logic       use_int = 1'b0;
   logic [1:0] ext_sel = 2'd0;
   logic [1:0] int_sel = 2'd0;
   logic [7:0] tbl = 8'b00_01_00_00;
   logic       drive, start, err, line;
   logic [1:0] base;
   int         n_chk = 0;
   int         n_err = 0;

   always #5 clk = ~clk;
   assign line = ~drive & ext_hold_n;

   rev_sel_ctrl u_dut (
      .clk (clk), .rst_n (rst_n), .cfg_cmd_i (cmd), .clr_line_i (line),
      .clr_drive_o (drive), .rev_en_i (rev_en), .use_int_i (use_int),
      .ext_sel_i (ext_sel), .int_sel_i (int_sel), .size_tbl_i (tbl),
      .start_o (start), .base_o (base), .sel_err_o (err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // watch for starts after a line release; expect one at count 3 if exp_start
   task automatic watch_release(input bit exp_start, input int exp_base, input int exp_err,
                                input string req);
      int starts = 0;
      int at_k = 0;
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         if (start) begin
            starts++;
            at_k = k;
            if (exp_start) begin
               check(base == exp_base, {req, " base"}, base, exp_base);
               check(err == exp_err, {req, " err"}, err, exp_err);
            end
         end
      end
      check(starts == (exp_start ? 1 : 0), {req, " start count"}, starts, exp_start ? 1 : 0);
      if (exp_start) check(at_k == 3, {req, " start latency"}, at_k, 3);
   endtask

   task automatic do_cfg(input bit ui, input logic [1:0] es, input logic [1:0] is,
                         input int exp_base, input int exp_err, input bit poke,
                         input string req);
      int n = 0;
      @(negedge clk);
      use_int = ui; ext_sel = es; int_sel = is; cmd = 1'b1;
      @(negedge clk);
      cmd = 1'b0;
      while (drive && n < 200) begin
         n++;
         if (poke && (n == 10 || n == LC)) cmd = 1'b1;
         @(negedge clk);
         cmd = 1'b0;
      end
      check(n == LC, "R1 pulse length", n, LC);
      watch_release(1'b1, exp_base, exp_err, req);
   endtask

   task automatic do_reset(input logic [7:0] t, input logic [1:0] es, input int exp_base);
      @(negedge clk);
      rst_n = 1'b0; tbl = t; ext_sel = es; use_int = 1'b0; rev_en = 1'b1;
      repeat (3) @(negedge clk);
      check(drive == 0 && start == 0 && err == 0 && base == 0, "R9 reset state",
            {drive, start, err, base}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(start == 1, "R8 power-on start", start, 1);
      check(base == exp_base, "R8 power-on base", base, exp_base);
      @(negedge clk);
      check(start == 0, "R8 single power-on start", start, 0);
   endtask

   // {use_int, ext_sel, int_sel, exp_base, exp_err}
   localparam logic [7:0] VEC [6] = '{
      {1'b0, 2'd1, 2'd2, 2'd1, 1'b0},
      {1'b1, 2'd1, 2'd2, 2'd2, 1'b0},
      {1'b0, 2'd0, 2'd3, 2'd0, 1'b0},
      {1'b1, 2'd3, 2'd0, 2'd0, 1'b0},
      {1'b0, 2'd2, 2'd1, 2'd2, 1'b0},
      {1'b0, 2'd3, 2'd0, 2'd0, 1'b1}
   };

   initial begin
      #(200000 * 10);
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      // sizes 1/1/2/1 units: bases 0,1,2, revision 3 out of range
      do_reset(8'b00_01_00_00, 2'd2, 2);

      // R4 R5 R6: table walk
      for (int i = 0; i < 6; i++) begin
         do_cfg(VEC[i][7], VEC[i][6:5], VEC[i][4:3], int'(VEC[i][2:1]), int'(VEC[i][0]),
                1'b0, "R4/R5/R6 vector");
      end

      // R6 flag stays after a valid selection
      do_cfg(1'b0, 2'd1, 2'd0, 1, 1, 1'b0, "R6 sticky");

      // R10 later pin changes do not move the base
      @(negedge clk);
      ext_sel = 2'd2; use_int = 1'b1; int_sel = 2'd2;
      repeat (4) @(negedge clk);
      check(base == 1, "R10 base held", base, 1);

      // R2 extra commands mid pulse and on its last cycle
      do_cfg(1'b0, 2'd2, 2'd0, 2, 1, 1'b1, "R2 ignored command");
      repeat (3) @(negedge clk);
      check(drive == 0, "R2 no repeated pulse", drive, 0);

      // R3 external clear activity
      @(negedge clk);
      use_int = 1'b0; ext_sel = 2'd1;
      ext_hold_n = 1'b0;
      repeat (5) @(negedge clk);
      ext_hold_n = 1'b1;
      watch_release(1'b1, 1, 1, "R3 external release");

      // R7 revisioning disabled
      @(negedge clk);
      rev_en = 1'b0; ext_sel = 2'd2;
      ext_hold_n = 1'b0;
      repeat (6) @(negedge clk);
      ext_hold_n = 1'b1;
      watch_release(1'b0, 0, 1, "R7 external ignored");
      check(base == 1, "R7 base untouched", base, 1);
      do_cfg(1'b0, 2'd2, 2'd3, 0, 1, 1'b0, "R7 command forces rev0");
      @(negedge clk);
      rev_en = 1'b1;

      // second table 1/3/1/1 units: rev1 base 1, rev2 out of range
      do_reset(8'b00_00_10_00, 2'd1, 1);
      do_cfg(1'b0, 2'd2, 2'd0, 0, 1, 1'b0, "R6 unequal sizes overflow");
      do_cfg(1'b1, 2'd0, 2'd1, 1, 1, 1'b0, "R5 unequal sizes base");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule